// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes an incoming Ethernet frame as a byte stream and stores it in a ring of fixed-size receive buffers. The frame stream carries start and end markers. Each buffer has one descriptor, made of an address word and a status word. A frame longer than one buffer fills consecutive buffers. When a frame reaches the last descriptor it continues in buffer 0, so software must join the part at the end of the ring with the part at the start.

The descriptor table and the buffer area are held in on-chip memory. Software reads descriptors and buffer bytes through a registered read port, and gives buffers back by clearing their ownership bits. The buffer area base comes from an input. Its low bits are ignored because buffers are aligned to their own size.

When the block needs a fresh buffer and that buffer is still owned, it drops the rest of the frame. It does not write into the owned buffer, and it pulses an overflow flag.

Top module: `rxr_ring_writer`

## Requirements
- R1: A frame byte at offset k of the buffer for descriptor d is stored at buffer-area address d*128+k. It is read back on `sw_buf_byte` when `sw_buf_addr` = {d, k}.
- R2: Bit 0 of an address word is the ownership bit. It is 0 after reset. The block sets it in the same cycle that it writes that descriptor's status. A pulse on `sw_clr_valid` clears the bit of descriptor `sw_clr_idx` from the next cycle, unless the block sets that same bit in that cycle, in which case setting wins.
- R3: In the address word of descriptor d, bits 31:7 are ring_base[31:7] + d and bits 6:2 are 0. Bit 1 is 1 only for the last descriptor. The ring_base[6:0] bits have no effect.
- R4: A buffer is closed when its 128th byte is written or when it takes the end-of-frame byte. In its status word, bit 14 is 1 if the buffer holds the frame's first byte, and bit 15 is 1 if it holds the frame's last byte.
- R5: Status bits 11:0 hold the total frame length in bytes on the end-of-frame descriptor, and hold 0 on every other descriptor.
- R6: Status bit 31 is 1 only on the end-of-frame descriptor of a frame of at least six bytes whose first six bytes are all 0xFF. Status bits 30:16 and 13:12 are always 0.
- R7: After the last descriptor the block continues with descriptor 0, also in the middle of a frame.
- R8: If a byte needs a fresh buffer whose ownership bit is 1, that byte and every later byte up to the next start-of-frame are dropped. The owned buffer and its status are left untouched. `rx_overflow` is 1 for exactly the cycle after that byte.
- R9: Bytes that arrive while no frame is open, and do not carry start-of-frame, are ignored. A start-of-frame byte that arrives while a frame is still open restarts storage at offset 0 of the current buffer, and the unfinished data is abandoned.
- R10: `sw_addr_word`, `sw_stat_word` and `sw_buf_byte` show the state before the clock edge at which their index was sampled, one cycle after that index is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| ring_base | input | 32 | Base address of the buffer area |
| sw_clr_valid | input | 1 | Request to clear an ownership bit |
| sw_clr_idx | input | $clog2(NUM_DESC) | Descriptor whose ownership bit is cleared |
| sw_desc_idx | input | $clog2(NUM_DESC) | Descriptor to read |
| sw_addr_word | output | 32 | Address word of the read descriptor |
| sw_stat_word | output | 32 | Status word of the read descriptor |
| sw_buf_addr | input | $clog2(NUM_DESC*BUF_BYTES) | Buffer-area byte address to read |
| sw_buf_byte | output | 8 | Byte read from the buffer area |
| rx_overflow | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench builds the block with four descriptors of 128 bytes. With so few descriptors, a single 300-byte frame passes the end of the ring and continues in buffer 0. Two more frames then leave every descriptor owned, so the overflow path is reached within a few hundred cycles. At the same time, a behavioural model of the ring follows every byte. Each cycle it is compared with the read ports, while the read indices sweep through the descriptors and buffer bytes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ST_BCAST_BIT = 31;
  localparam int ST_LAST_BIT  = 15;
  localparam int ST_FIRST_BIT = 14;
  localparam int ST_LEN_W     = 12;
  localparam int AW_OWN_BIT   = 0;
  localparam int AW_WRAP_BIT  = 1;

  function automatic logic [31:0] mk_status(input logic bcast, input logic last,
                                            input logic first,
                                            input logic [ST_LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[ST_BCAST_BIT] = bcast;
    w[ST_LAST_BIT]  = last;
    w[ST_FIRST_BIT] = first;
    w[ST_LEN_W-1:0] = len;
    return w;
  endfunction
endpackage

// File: rtl/rxr_sdp_ram.sv
module rxr_sdp_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxr_own_table.sv
module rxr_own_table #(
  parameter int NUM_DESC  = 16,
  parameter int BUF_BYTES = 128,
  localparam int IDXW = $clog2(NUM_DESC),
  localparam int OFFW = $clog2(BUF_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [IDXW-1:0]     set_idx,
  input  logic                clr_en,
  input  logic [IDXW-1:0]     clr_idx,
  input  logic [IDXW-1:0]     rd_idx,
  input  logic [31:0]         ring_base,
  output logic [NUM_DESC-1:0] own_q,
  output logic [31:0]         addr_word
);
  import rxr_pkg::*;

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_own
    always_ff @(posedge clk) begin
      if (rst)                                  own_q[i] <= 1'b0;
      else if (set_en && set_idx == IDXW'(i))   own_q[i] <= 1'b1;
      else if (clr_en && clr_idx == IDXW'(i))   own_q[i] <= 1'b0;
    end
  end

  logic [31:0] base_al, word_c;

  always_comb begin
    base_al = ring_base & ~32'(BUF_BYTES - 1);
    word_c  = base_al + (32'(rd_idx) << OFFW);
    word_c[AW_WRAP_BIT] = (rd_idx == IDXW'(NUM_DESC - 1));
    word_c[AW_OWN_BIT]  = own_q[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) addr_word <= '0;
    else     addr_word <= word_c;
  end
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl #(
  parameter int NUM_DESC  = 16,
  parameter int BUF_BYTES = 128,
  localparam int IDXW = $clog2(NUM_DESC),
  localparam int OFFW = $clog2(BUF_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 rx_sof,
  input  logic                 rx_eof,
  input  logic [NUM_DESC-1:0]  own_q,
  output logic                 buf_we,
  output logic [IDXW-1:0]      buf_widx,
  output logic [IDXW+OFFW-1:0] buf_waddr,
  output logic [7:0]           buf_wdata,
  output logic                 stat_we,
  output logic [IDXW-1:0]      stat_widx,
  output logic [31:0]          stat_wdata,
  output logic                 rx_overflow
);
  import rxr_pkg::*;

  logic            active_q, start_q, bc_q;
  logic [IDXW-1:0] cur_q;
  logic [OFFW-1:0] fill_q;
  logic [15:0]     len_q;

  logic            take, blocked, wr, closing, first_eff, bc_eff, bc_final;
  logic [OFFW-1:0] fill_eff;
  logic [15:0]     pos, len_n;
  logic [IDXW-1:0] next_idx;

  always_comb begin
    take      = rx_valid && (rx_sof || active_q);
    fill_eff  = rx_sof ? '0 : fill_q;
    blocked   = take && (fill_eff == '0) && own_q[cur_q];
    wr        = take && !blocked;
    pos       = rx_sof ? 16'd0 : len_q;
    len_n     = pos + 16'd1;
    first_eff = rx_sof || start_q;
    bc_eff    = (rx_sof || bc_q) && !((pos < 16'd6) && (rx_data != 8'hFF));
    bc_final  = bc_eff && (len_n >= 16'd6) && rx_eof;
    closing   = wr && (rx_eof || fill_eff == OFFW'(BUF_BYTES - 1));
    next_idx  = (cur_q == IDXW'(NUM_DESC - 1)) ? '0 : cur_q + IDXW'(1);
  end

  assign buf_we     = wr;
  assign buf_widx   = cur_q;
  assign buf_waddr  = {cur_q, fill_eff};
  assign buf_wdata  = rx_data;
  assign stat_we    = closing;
  assign stat_widx  = cur_q;
  assign stat_wdata = mk_status(bc_final, rx_eof, first_eff,
                                rx_eof ? len_n[ST_LEN_W-1:0] : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      start_q     <= 1'b0;
      bc_q        <= 1'b0;
      cur_q       <= '0;
      fill_q      <= '0;
      len_q       <= '0;
      rx_overflow <= 1'b0;
    end else begin
      rx_overflow <= blocked;
      if (blocked) begin
        active_q <= 1'b0;
        fill_q   <= '0;
      end else if (wr) begin
        len_q <= len_n;
        bc_q  <= bc_eff;
        if (closing) begin
          cur_q    <= next_idx;
          fill_q   <= '0;
          start_q  <= 1'b0;
          active_q <= !rx_eof;
        end else begin
          fill_q   <= fill_eff + OFFW'(1);
          start_q  <= first_eff;
          active_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int NUM_DESC  = 16,
  parameter int BUF_BYTES = 128
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  rx_valid,
  input  logic [7:0]                            rx_data,
  input  logic                                  rx_sof,
  input  logic                                  rx_eof,
  input  logic [31:0]                           ring_base,
  input  logic                                  sw_clr_valid,
  input  logic [$clog2(NUM_DESC)-1:0]           sw_clr_idx,
  input  logic [$clog2(NUM_DESC)-1:0]           sw_desc_idx,
  output logic [31:0]                           sw_addr_word,
  output logic [31:0]                           sw_stat_word,
  input  logic [$clog2(NUM_DESC*BUF_BYTES)-1:0] sw_buf_addr,
  output logic [7:0]                            sw_buf_byte,
  output logic                                  rx_overflow
);
  localparam int IDXW = $clog2(NUM_DESC);
  localparam int BAW  = $clog2(NUM_DESC * BUF_BYTES);

  logic [NUM_DESC-1:0] own_q;
  logic                buf_we, stat_we;
  logic [IDXW-1:0]     buf_widx, stat_widx;
  logic [BAW-1:0]      buf_waddr;
  logic [7:0]          buf_wdata;
  logic [31:0]         stat_wdata;

  rxr_fill_ctrl #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) fill_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .own_q(own_q),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .stat_we(stat_we), .stat_widx(stat_widx),
    .stat_wdata(stat_wdata), .rx_overflow(rx_overflow)
  );

  rxr_own_table #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) own_i (
    .clk(clk), .rst(rst), .set_en(stat_we), .set_idx(stat_widx),
    .clr_en(sw_clr_valid), .clr_idx(sw_clr_idx), .rd_idx(sw_desc_idx),
    .ring_base(ring_base), .own_q(own_q), .addr_word(sw_addr_word)
  );

  rxr_sdp_ram #(.DEPTH(NUM_DESC), .WIDTH(32)) stat_ram_i (
    .clk(clk), .we(stat_we), .waddr(stat_widx), .wdata(stat_wdata),
    .raddr(sw_desc_idx), .rdata(sw_stat_word)
  );

  rxr_sdp_ram #(.DEPTH(NUM_DESC * BUF_BYTES), .WIDTH(8)) buf_ram_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(sw_buf_addr), .rdata(sw_buf_byte)
  );
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
  parameter int NUM_DESC = 16,
  localparam int IDXW = $clog2(NUM_DESC)
) (
  input logic                clk,
  input logic                rst,
  input logic                rx_valid,
  input logic                sw_clr_valid,
  input logic [IDXW-1:0]     sw_clr_idx,
  input logic [IDXW-1:0]     sw_desc_idx,
  input logic [31:0]         sw_addr_word,
  input logic                rx_overflow,
  input logic [NUM_DESC-1:0] own_q,
  input logic                buf_we,
  input logic [IDXW-1:0]     buf_widx,
  input logic                stat_we,
  input logic [IDXW-1:0]     stat_widx,
  input logic [31:0]         stat_wdata
);
  AST_SET_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> own_q[$past(stat_widx)]); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    sw_clr_valid && !(stat_we && stat_widx == sw_clr_idx)
      |=> !own_q[$past(sw_clr_idx)]); // R2

  AST_WRAP_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
    sw_addr_word[1] |-> $past(sw_desc_idx) == IDXW'(NUM_DESC - 1)); // R3

  AST_EOF_HAS_LEN: assert property (@(posedge clk) disable iff (rst)
    stat_we && stat_wdata[15] |-> stat_wdata[11:0] != 12'd0); // R5

  AST_NO_WRITE_OWNED: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !own_q[buf_widx]); // R8

  AST_OVF_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |-> $past(rx_valid)); // R8
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.NUM_DESC(NUM_DESC)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .sw_clr_valid(sw_clr_valid),
  .sw_clr_idx(sw_clr_idx), .sw_desc_idx(sw_desc_idx),
  .sw_addr_word(sw_addr_word), .rx_overflow(rx_overflow), .own_q(own_q),
  .buf_we(buf_we), .buf_widx(buf_widx), .stat_we(stat_we),
  .stat_widx(stat_widx), .stat_wdata(stat_wdata)
);

// File: tb/rxr_ring_writer_tb.sv
module rxr_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int BB  = 128;
  localparam int IW  = $clog2(N);
  localparam int BAW = $clog2(N * BB);

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = '0;
  logic [31:0] ring_base = 32'h2000_0055;
  logic sw_clr_valid = 0;
  logic [IW-1:0] sw_clr_idx = '0, sw_desc_idx = '0;
  logic [BAW-1:0] sw_buf_addr = '0;
  logic [31:0] sw_addr_word, sw_stat_word;
  logic [7:0] sw_buf_byte;
  logic rx_overflow;

  int n_chk = 0, n_err = 0, cyc = 0, ovf_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_ring_writer #(.NUM_DESC(N), .BUF_BYTES(BB)) dut_i (.*);

  // behavioural reference model
  bit m_own[N]; int m_stat[N]; bit m_sv[N];
  byte unsigned m_buf[N*BB]; bit m_bv[N*BB];
  int m_cur, m_fill, m_len; bit m_act, m_first, m_bc;
  logic [31:0] e_addr, e_stat; logic [7:0] e_buf; bit e_sv, e_bv, e_ovf;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_own[i]) begin m_own[i] = 0; m_sv[i] = 0; end
      foreach (m_bv[i]) m_bv[i] = 0;
      m_cur = 0; m_fill = 0; m_len = 0; m_act = 0; m_first = 0; m_bc = 0;
      e_addr = 0; e_sv = 0; e_bv = 0; e_ovf = 0;
    end else begin
      int set_i;
      set_i = -1;
      e_addr = (ring_base & 32'hFFFF_FF80) + 32'(int'(sw_desc_idx) * BB)
             + ((int'(sw_desc_idx) == N-1) ? 2 : 0) + 32'(m_own[sw_desc_idx]);
      e_sv = m_sv[sw_desc_idx]; e_stat = m_stat[sw_desc_idx];
      e_bv = m_bv[sw_buf_addr]; e_buf = m_buf[sw_buf_addr];
      e_ovf = 0;
      if (rx_valid && (rx_sof || m_act)) begin
        if (rx_sof) begin m_fill = 0; m_len = 0; m_first = 1; m_bc = 1; m_act = 1; end
        if (m_fill == 0 && m_own[m_cur]) begin
          e_ovf = 1; m_act = 0;
        end else begin
          if (m_len < 6 && rx_data != 8'hFF) m_bc = 0;
          m_buf[m_cur*BB + m_fill] = rx_data; m_bv[m_cur*BB + m_fill] = 1;
          m_len++; m_fill++;
          if (rx_eof || m_fill == BB) begin
            m_stat[m_cur] = (m_first ? 32'h4000 : 0) | (rx_eof ? 32'h8000 : 0)
                          | (rx_eof ? (m_len & 32'hFFF) : 0)
                          | ((rx_eof && m_bc && m_len >= 6) ? 32'h8000_0000 : 0);
            m_sv[m_cur] = 1; m_own[m_cur] = 1; set_i = m_cur;
            m_cur = (m_cur + 1) % N; m_fill = 0; m_first = 0;
            if (rx_eof) m_act = 0;
          end
        end
      end
      if (sw_clr_valid && int'(sw_clr_idx) != set_i) m_own[sw_clr_idx] = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R3 R10 address word", sw_addr_word, e_addr);
      chk("R8 overflow pulse", 32'(rx_overflow), 32'(e_ovf));
      if (e_sv) chk("R4 R5 R6 R10 status word", sw_stat_word, e_stat);
      if (e_bv) chk("R1 R10 buffer byte", 32'(sw_buf_byte), 32'(e_buf));
      if (rx_overflow) ovf_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int i, int seed);
    return (seed == 0 && i < 6) ? 8'hFF : 8'(i*7 + seed);
  endfunction

  task automatic send(int n, int seed, bit sof, bit eof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = sof && (i == 0); rx_eof = eof && (i == n-1);
      rx_data = pat(i, seed);
      sw_desc_idx = IW'(i % N); sw_buf_addr = BAW'((i*53) % (N*BB));
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic rd(int idx, int baddr);
    @(negedge clk);
    sw_desc_idx = IW'(idx); sw_buf_addr = BAW'(baddr);
    @(negedge clk);
  endtask

  task automatic clr(int idx);
    @(negedge clk);
    sw_clr_valid = 1; sw_clr_idx = IW'(idx);
    @(negedge clk);
    sw_clr_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(3, 0); chk("R3 last desc addr, low base bits ignored", sw_addr_word, 32'h2000_0182);
    chk("R8 no overflow after reset", 32'(rx_overflow), 0);
    rd(0, 0); chk("R2 R3 reset addr word desc0", sw_addr_word, 32'h2000_0000);

    send(200, 0, 1, 1);                          // broadcast, two buffers
    rd(0, 0); chk("R4 full first buffer status", sw_stat_word, 32'h0000_4000);
    chk("R2 owned after close", sw_addr_word, 32'h2000_0001);
    rd(1, 128 + 71); chk("R5 R6 end buffer status", sw_stat_word, 32'h8000_80C8);
    chk("R1 byte 199 location", 32'(sw_buf_byte), 32'(pat(199, 0)));

    send(5, 0, 1, 1);                            // short all-FF frame
    rd(2, 0); chk("R6 short frame not broadcast", sw_stat_word, 32'h0000_C005);

    clr(0); clr(1);
    rd(0, 0); chk("R2 cleared by software", sw_addr_word, 32'h2000_0000);

    send(300, 3, 1, 1);                          // 3 -> 0 -> 1 wrap
    rd(3, 0); chk("R7 head part status", sw_stat_word, 32'h0000_4000);
    rd(0, 0); chk("R7 middle buffer status", sw_stat_word, 32'h0000_0000);
    chk("R7 wrapped byte in buffer 0", 32'(sw_buf_byte), 32'(pat(128, 3)));
    rd(1, 0); chk("R5 R7 tail status", sw_stat_word, 32'h0000_812C);

    send(10, 9, 1, 1);                           // desc 2 still owned
    chk("R8 one overflow pulse", ovf_cnt, 1);
    rd(2, 256); chk("R8 owned status untouched", sw_stat_word, 32'h0000_C005);
    chk("R8 owned buffer untouched", 32'(sw_buf_byte), 32'hFF);

    clr(2);
    send(3, 5, 0, 1);                            // stray bytes
    rd(2, 0); chk("R9 stray bytes ignored", sw_addr_word, 32'h2000_0100);
    send(10, 11, 1, 0);
    send(4, 13, 1, 1);                           // restart mid-frame
    rd(2, 256); chk("R9 restart status", sw_stat_word, 32'h0000_C004);
    chk("R9 restart byte 0", 32'(sw_buf_byte), 32'(pat(0, 13)));
    chk("R2 restart buffer owned", sw_addr_word, 32'h2000_0101);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule